// File: doc/BRIEF.md
# Shared Mailbox Array with Level Interrupts

This block holds a bank of one-word mailboxes that two agents share over a simple register bus: a producer posts a word and a consumer takes it. The most significant bit of each stored word doubles as the occupancy flag. A word written with that bit set makes the mailbox full. A word of all zeros written back by the consumer makes it empty again.

From the occupancy of every mailbox the block forms a 16-bit status vector. It holds one empty bit and one full bit per mailbox. Every shared interrupt output has its own mask register, and an output is high while any status bit selected by its mask is high. Status is a level, not an event. An empty mailbox therefore holds an enabled line high until a producer fills it. A build option adds two enable bits per mailbox, one for its full status and one for its empty status. A read-only word reports how many resources of each kind the block was built with.

Top module: `mbx_array`

## Requirements
- R1: After reset every mailbox word is zero, every interrupt mask is zero, every interrupt output is low, and each built mailbox's two per-mailbox enable bits read 1.
- R2: Mailbox i has its data word at byte address 0x10000 + i*0x8000. A read returns the last word written. Bit 31 of the word is the full flag, so a write with bit 31 set makes full status bit 8+i high and empty status bit i low.
- R3: Writing zero to a mailbox data word clears the payload and the full flag together, and the mailbox's empty status bit returns.
- R4: The status word at address 0x304 carries empty bits in [7:0] and full bits in [15:8], indexed by mailbox. Bits of mailboxes that are not built read 0, and writes to this address change nothing.
- R5: Line n has its mask at address 0x100 + 4*n, and the mask reads back as written in bits [15:0]. Output irq_o[n] is high exactly while (status AND mask) is nonzero, and it stays high as long as that holds, with no bus activity needed.
- R6: With per-mailbox enables built, bit 0 at window offset 0x04 enables the full status bit and bit 0 at offset 0x08 enables the empty status bit. A cleared enable forces its status bit to 0.
- R7: The word at address 0x380 reads {12'h0, lines[19:16], doorbells[15:12], async semaphores[11:8], sync semaphores[7:4], mailboxes[3:0]}, and writes to it are ignored.
- R8: Unmapped addresses read 0 and writes to them change nothing. This includes the window of a mailbox index at or above the built count and a mask address at or above the built line count.
- R9: Several lines may select the same status bit, and each follows its own mask independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_o | output | NUM_IRQ | Level-sensitive shared interrupt lines |

## Verification
On every cycle the assertions check the following. A mailbox never shows empty and full status at once. Status bits of unbuilt mailboxes stay zero. A write to the status word leaves it unchanged. A data write with bit 31 set gives a full mailbox on the next cycle, and a zero write gives an empty one. An interrupt line moves only after a bus write, and a zeroed mask drops its line. Only the bench's scenarios show the rest: exact readback values and the status encoding, an empty line held high across idle cycles, the masking effect of the per-mailbox enables, the dimension word, and that out-of-range windows and mask addresses are ignored.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
    localparam int WORD_W   = 32;
    localparam int STAT_W   = 16;
    localparam int FULL_LSB = 8;
    localparam int MAX_MB   = 8;
    localparam int WIN_LG   = 15;            // 32 KiB per mailbox window
    localparam int MB_BASE  = 32'h0001_0000; // first window
    localparam int OFS_DATA = 0;
    localparam int OFS_FIE  = 4;
    localparam int OFS_EIE  = 8;
    localparam int MASK_BASE = 32'h100;
    localparam int STAT_ADDR = 32'h304;
    localparam int DIMS_ADDR = 32'h380;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              fie;
        logic              eie;
    } slot_t;
endpackage

// File: rtl/mbx_slot.sv
`timescale 1ns/1ps
module mbx_slot
    import mbx_pkg::*;
#(
    parameter bit PER_MB_IE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_word,
    input  logic              wr_fie,
    input  logic              wr_eie,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] word_o,
    output logic              fie_o,
    output logic              eie_o,
    output logic              full_o,
    output logic              full_st_o,
    output logic              empty_st_o
);
    slot_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_word)              s_d.word = wdata;
        if (wr_fie && PER_MB_IE)  s_d.fie  = wdata[0];
        if (wr_eie && PER_MB_IE)  s_d.eie  = wdata[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.word <= '0;
            s_q.fie  <= 1'b1;
            s_q.eie  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign word_o     = s_q.word;
    assign fie_o      = s_q.fie;
    assign eie_o      = s_q.eie;
    assign full_o     = s_q.word[WORD_W-1];
    assign full_st_o  = full_o & s_q.fie;
    assign empty_st_o = ~full_o & s_q.eie;
endmodule

// File: rtl/mbx_irq_route.sv
`timescale 1ns/1ps
module mbx_irq_route
    import mbx_pkg::*;
#(
    parameter int NUM_IRQ = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_IRQ-1:0]               wr_line,
    input  logic [STAT_W-1:0]                wdata,
    input  logic [STAT_W-1:0]                status,
    output logic [NUM_IRQ-1:0][STAT_W-1:0]   mask_o,
    output logic [NUM_IRQ-1:0]               irq_o
);
    typedef struct packed {
        logic [NUM_IRQ-1:0][STAT_W-1:0] masks;
    } route_t;

    route_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        for (int n = 0; n < NUM_IRQ; n++) begin
            if (wr_line[n]) r_d.masks[n] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        for (int n = 0; n < NUM_IRQ; n++) begin
            irq_o[n] = |(r_q.masks[n] & status);
        end
    end

    assign mask_o = r_q.masks;
endmodule

// File: rtl/mbx_array.sv
`timescale 1ns/1ps
module mbx_array
    import mbx_pkg::*;
#(
    parameter int NUM_MB    = 8,
    parameter int NUM_IRQ   = 4,
    parameter int NUM_SSEM  = 4,
    parameter int NUM_ASEM  = 4,
    parameter int NUM_DBELL = 8,
    parameter bit PER_MB_IE = 1'b1,
    parameter int ADDR_W    = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    output logic [NUM_IRQ-1:0]  irq_o
);
    localparam int WIN_W = ADDR_W - WIN_LG;
    localparam logic [ADDR_W-1:0] MB_BASE_A  = ADDR_W'(MB_BASE);
    localparam logic [ADDR_W-1:0] MASK_A     = ADDR_W'(MASK_BASE);
    localparam logic [ADDR_W-1:0] STAT_A     = ADDR_W'(STAT_ADDR);
    localparam logic [ADDR_W-1:0] DIMS_A     = ADDR_W'(DIMS_ADDR);
    localparam logic [WORD_W-1:0] DIMS_WORD  = {12'h0, 4'(NUM_IRQ), 4'(NUM_DBELL),
                                                4'(NUM_ASEM), 4'(NUM_SSEM), 4'(NUM_MB)};

    // address decode
    logic                wr;
    logic                in_mb;
    logic [ADDR_W-1:0]   rel;
    logic [WIN_W-1:0]    win;
    logic [WIN_LG-1:0]   low;
    logic [NUM_MB-1:0]   slot_hit;
    logic [NUM_IRQ-1:0]  line_hit;
    logic                stat_hit, dims_hit;

    assign wr  = bus_sel & bus_we;
    assign rel = bus_addr - MB_BASE_A;
    assign win = rel[ADDR_W-1:WIN_LG];
    assign low = rel[WIN_LG-1:0];
    assign in_mb    = (bus_addr >= MB_BASE_A);
    assign stat_hit = (bus_addr == STAT_A);
    assign dims_hit = (bus_addr == DIMS_A);

    // per-slot state
    logic [NUM_MB-1:0][WORD_W-1:0] words;
    logic [NUM_MB-1:0] fie_v, eie_v, full_raw_w, full_st, empty_st;
    logic [STAT_W-1:0] status_w;
    logic [NUM_IRQ-1:0][STAT_W-1:0] masks;

    for (genvar i = 0; i < NUM_MB; i++) begin : g_slot
        assign slot_hit[i] = in_mb && (win == WIN_W'(i));

        mbx_slot #(.PER_MB_IE(PER_MB_IE)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_word    (wr && slot_hit[i] && (low == WIN_LG'(OFS_DATA))),
            .wr_fie     (wr && slot_hit[i] && (low == WIN_LG'(OFS_FIE))),
            .wr_eie     (wr && slot_hit[i] && (low == WIN_LG'(OFS_EIE))),
            .wdata      (bus_wdata),
            .word_o     (words[i]),
            .fie_o      (fie_v[i]),
            .eie_o      (eie_v[i]),
            .full_o     (full_raw_w[i]),
            .full_st_o  (full_st[i]),
            .empty_st_o (empty_st[i])
        );
    end

    for (genvar n = 0; n < NUM_IRQ; n++) begin : g_line
        assign line_hit[n] = (bus_addr == MASK_A + ADDR_W'(4 * n));
    end

    always_comb begin
        status_w = '0;
        for (int i = 0; i < NUM_MB; i++) begin
            status_w[i]            = empty_st[i];
            status_w[FULL_LSB + i] = full_st[i];
        end
    end

    mbx_irq_route #(.NUM_IRQ(NUM_IRQ)) u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_line (line_hit & {NUM_IRQ{wr}}),
        .wdata   (bus_wdata[STAT_W-1:0]),
        .status  (status_w),
        .mask_o  (masks),
        .irq_o   (irq_o)
    );

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (stat_hit) bus_rdata = WORD_W'(status_w);
        if (dims_hit) bus_rdata = DIMS_WORD;
        for (int n = 0; n < NUM_IRQ; n++) begin
            if (line_hit[n]) bus_rdata = WORD_W'(masks[n]);
        end
        for (int i = 0; i < NUM_MB; i++) begin
            if (slot_hit[i]) begin
                if (low == WIN_LG'(OFS_DATA)) bus_rdata = words[i];
                if (PER_MB_IE && low == WIN_LG'(OFS_FIE)) bus_rdata = WORD_W'(fie_v[i]);
                if (PER_MB_IE && low == WIN_LG'(OFS_EIE)) bus_rdata = WORD_W'(eie_v[i]);
            end
        end
    end
endmodule

// File: rtl/mbx_array_chk.sv
`timescale 1ns/1ps
module mbx_array_chk
    import mbx_pkg::*;
#(
    parameter int NUM_MB  = 8,
    parameter int NUM_IRQ = 4,
    parameter int ADDR_W  = 20
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_sel,
    input logic                bus_we,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [WORD_W-1:0]   bus_wdata,
    input logic [STAT_W-1:0]   status,
    input logic [NUM_MB-1:0]   full_raw,
    input logic [NUM_IRQ-1:0]  irq_o
);
    logic wr;
    assign wr = bus_sel && bus_we;

    // R1: interrupts and occupancy are clear as reset is released
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_o == '0 && full_raw == '0));

    // R4: status is read-only
    a_r4_status_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == ADDR_W'(STAT_ADDR)) |=> $stable(status));

    // R5: lines move only after a bus write
    a_r5_irq_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(irq_o));

    for (genvar i = 0; i < MAX_MB; i++) begin : g_mb
        if (i < NUM_MB) begin : g_built
            localparam logic [ADDR_W-1:0] DA = ADDR_W'(MB_BASE + i * (1 << WIN_LG));
            a_r2_full_set: assert property (@(posedge clk) disable iff (!rst_n)
                (wr && bus_addr == DA && bus_wdata[WORD_W-1]) |=> full_raw[i]);
            a_r3_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
                (wr && bus_addr == DA && bus_wdata == '0) |=> !full_raw[i]);
            a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
                !(status[i] && status[FULL_LSB + i]));
        end else begin : g_unbuilt
            a_r4_unbuilt_zero: assert property (@(posedge clk) disable iff (!rst_n)
                !status[i] && !status[FULL_LSB + i]);
        end
    end

    for (genvar n = 0; n < NUM_IRQ; n++) begin : g_ln
        a_r5_mask_zero_drops: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && bus_addr == ADDR_W'(MASK_BASE + 4 * n) && bus_wdata[STAT_W-1:0] == '0)
            |=> !irq_o[n]);
    end
endmodule

bind mbx_array mbx_array_chk #(
    .NUM_MB  (NUM_MB),
    .NUM_IRQ (NUM_IRQ),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .status    (status_w),
    .full_raw  (full_raw_w),
    .irq_o     (irq_o)
);

// File: tb/mbx_array_test.sv
`timescale 1ns/1ps
module mbx_array_test;
    localparam int NMB = 6;
    localparam int NIRQ = 4;
    localparam int AW = 20;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_sel = 1'b0;
    logic            bus_we = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NIRQ-1:0] irq_o;

    mbx_array #(.NUM_MB(NMB), .NUM_IRQ(NIRQ), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o)
    );

    always #2 clk = ~clk;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];
    logic  mon_go = 1'b0;
    int    n_chk = 0;
    int    n_err = 0;
    bit    done = 1'b0;

    function automatic logic [AW-1:0] mb_a(int i, int ofs);
        return AW'(32'h1_0000 + i * 32'h8000 + ofs);
    endfunction

    // monitor: pops the expected item and compares away from the clock edge
    always @(negedge clk) begin
        if (mon_go && sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            act = it.is_irq ? 32'(irq_o) : bus_rdata;
            n_chk++;
            if (act !== it.exp) begin
                n_err++;
                $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        mon_go = 1'b0; bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; bus_wdata = '0;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        sb.push_back(it);
        mon_go = 1'b1;
    endtask

    task automatic irq_chk(input logic [NIRQ-1:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_we = 1'b0;
        it.is_irq = 1'b1; it.exp = 32'(e); it.tag = tag;
        sb.push_back(it);
        mon_go = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
            mon_go = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd_chk(AW'(32'h304), 32'h0000_003F, "R1 status after reset");
        rd_chk(AW'(32'h100), 32'h0, "R1 mask0 after reset");
        irq_chk(4'b0000, "R1 irq low after reset");
        rd_chk(mb_a(0, 0), 32'h0, "R1 mailbox0 word after reset");
        rd_chk(mb_a(0, 4), 32'h1, "R1 full enable resets to 1");

        // R7 dimension word
        rd_chk(AW'(32'h380), 32'h0004_8446, "R7 dimensions");
        wr(AW'(32'h380), 32'hFFFF_FFFF);
        rd_chk(AW'(32'h380), 32'h0004_8446, "R7 dimensions read-only");

        // R2 post with full flag
        wr(mb_a(1, 0), 32'h8000_1234);
        rd_chk(mb_a(1, 0), 32'h8000_1234, "R2 readback full word");
        rd_chk(AW'(32'h304), 32'h0000_023D, "R2 status after fill");
        // R2 payload without flag stays empty
        wr(mb_a(3, 0), 32'h0000_00AA);
        rd_chk(mb_a(3, 0), 32'h0000_00AA, "R2 readback flagless word");
        rd_chk(AW'(32'h304), 32'h0000_023D, "R2 flagless word not full");

        // R3 consumer clears
        wr(mb_a(1, 0), 32'h0);
        rd_chk(mb_a(1, 0), 32'h0, "R3 cleared word");
        rd_chk(AW'(32'h304), 32'h0000_003F, "R3 status after clear");

        // R4 status read-only
        wr(AW'(32'h304), 32'h0000_FFFF);
        rd_chk(AW'(32'h304), 32'h0000_003F, "R4 status ignores write");

        // R5 level interrupt on empty
        wr(AW'(32'h100), 32'h0000_0004);
        irq_chk(4'b0001, "R5 empty mb2 raises line0");
        idle(5);
        irq_chk(4'b0001, "R5 line0 held while empty");
        wr(mb_a(2, 0), 32'h8000_0000);
        irq_chk(4'b0000, "R5 fill drops line0");
        rd_chk(AW'(32'h304), 32'h0000_043B, "R4 status mb2 full");
        wr(AW'(32'h108), 32'h0000_0400);
        irq_chk(4'b0100, "R5 full mb2 raises line2");
        // R9 shared bit on two lines
        wr(AW'(32'h10C), 32'h0000_0400);
        irq_chk(4'b1100, "R9 two lines share full bit");
        rd_chk(AW'(32'h108), 32'h0000_0400, "R5 mask readback");

        // R6 per-mailbox enables
        wr(mb_a(2, 4), 32'h0);
        rd_chk(AW'(32'h304), 32'h0000_003B, "R6 full enable off hides full bit");
        irq_chk(4'b0000, "R6 lines drop with full enable off");
        rd_chk(mb_a(2, 4), 32'h0, "R6 full enable readback");
        wr(mb_a(4, 8), 32'h0);
        rd_chk(AW'(32'h304), 32'h0000_002B, "R6 empty enable off hides empty bit");
        wr(mb_a(2, 4), 32'h1);
        irq_chk(4'b1100, "R6 full enable restored");

        // R3 consumer empties mb2
        wr(mb_a(2, 0), 32'h0);
        irq_chk(4'b0001, "R3 clear moves irq to empty line");
        rd_chk(AW'(32'h304), 32'h0000_002F, "R3 status after mb2 clear");

        // R8 unmapped and unbuilt ranges
        wr(mb_a(6, 0), 32'h8000_0001);
        rd_chk(mb_a(6, 0), 32'h0, "R8 unbuilt window reads 0");
        rd_chk(AW'(32'h304), 32'h0000_002F, "R8 unbuilt write no effect");
        wr(AW'(32'h110), 32'h0000_FFFF);
        rd_chk(AW'(32'h110), 32'h0, "R8 mask beyond lines reads 0");
        irq_chk(4'b0001, "R8 irq unchanged by out-of-range mask write");
        wr(AW'(32'h200), 32'h1234_5678);
        rd_chk(AW'(32'h200), 32'h0, "R8 unmapped reads 0");

        // R5 zero mask drops line
        wr(AW'(32'h100), 32'h0);
        irq_chk(4'b0000, "R5 cleared mask drops line0");

        idle(2);
        if (sb.size() != 0) begin
            n_err++;
            $display("FAIL scoreboard: actual=%0d expected=0 leftover items", sb.size());
        end
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule